// File: doc/BRIEF.md
# Table-Write Pointer and Holding Buffer

This block carries out the datapath side of a table-write instruction. It keeps a 21-bit byte pointer, an 8-bit latch byte and a bank of eight byte-wide holding registers that later feed program-memory programming. When a valid table-write opcode arrives, the block copies the latch byte into one holding register and, depending on the opcode's two-bit mode field, keeps the pointer, moves it up or down by one after the write, or moves it up by one before the write.

Each instruction takes two cycles. The acceptance edge captures the mode and raises `busy` for one cycle. The following edge does the write and the pointer change together and raises `done` for one cycle. Software-visible state is loaded through separate pointer and latch load ports, and any holding register can be read back through a combinational read port.

Top module: `tblwr_unit`

## Requirements
- R1: With `rst_n` low at a clock edge, the pointer, the latch and all eight holding registers become zero, and `busy` and `done` become 0.
- R2: An instruction is accepted only when its 16-bit word is 0x000C to 0x000F (bits [15:2] equal 0x0003). Any other word raises neither `busy` nor `done` and changes neither the pointer nor any holding register.
- R3: Mode field bits [1:0] = 0 (keep): the latch byte goes into the holding register selected by pointer bits [2:0], and the pointer is unchanged.
- R4: Mode 1 (post-increment): the write uses the old pointer bits [2:0], and then the pointer becomes old+1. Example: 0x00A356 with latch 0x55 writes offset 6 and leaves 0x00A357.
- R5: Mode 2 (post-decrement): the write uses the old pointer bits [2:0], and then the pointer becomes old-1.
- R6: Mode 3 (pre-increment): the pointer becomes old+1, and bits [2:0] of the new value select the register. Example: 0x01389A with latch 0x34 writes offset 3 and leaves 0x01389B.
- R7: Pointer arithmetic wraps modulo 2^21: 0x1FFFFF+1 = 0x000000 and 0x000000-1 = 0x1FFFFF.
- R8: `busy` is high for exactly the one cycle after acceptance, and an instruction presented while `busy` is high is ignored. `done` is high for exactly the one cycle after the write edge. The pointer and holding results are visible in that same cycle.
- R9: A pointer load in the cycle where an instruction updates the pointer is discarded, and the instruction's result stands. A pointer load in the acceptance cycle takes effect, and the instruction then works on the loaded value.
- R10: `ptr_ld` and `lat_ld` load their data at the next edge. `rd_data` shows the holding register chosen by `rd_sel` without a clock delay. The write uses the latch value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr_word | input | 16 | Instruction word |
| ptr_ld | input | 1 | Load pointer from ptr_din |
| ptr_din | input | 21 | Pointer load value |
| lat_ld | input | 1 | Load latch from lat_din |
| lat_din | input | 8 | Latch load value |
| rd_sel | input | 3 | Holding register read index |
| rd_data | output | 8 | Selected holding register |
| ptr_q | output | 21 | Current pointer |
| lat_q | output | 8 | Current latch byte |
| busy | output | 1 | Instruction in its execute cycle |
| done | output | 1 | Instruction completed at the last edge |

## Verification
A pointer load and an instruction's pointer update can land on the same edge. The bench causes this by raising `ptr_ld` with a distinct value during the busy cycle, and expects the load to be lost and the pointer to show the arithmetic result. It also raises `ptr_ld` together with the instruction in the acceptance cycle, and expects the write and the update to use the loaded value. A second overlap, a new instruction arriving while `busy` is high, is judged by checking that `busy` falls and that only one pointer step occurred.

// File: rtl/tblwr_pkg.sv
// Shared types for the table-write unit.
// Assumes the mode field of the opcode occupies its two low bits.
package tblwr_pkg;
    typedef enum logic [1:0] {
        TW_KEEP    = 2'd0,
        TW_POSTINC = 2'd1,
        TW_POSTDEC = 2'd2,
        TW_PREINC  = 2'd3
    } tw_mode_e;
endpackage

// File: rtl/tblwr_decode.sv
// Opcode decoder: flags a table-write word and extracts its update mode.
// Assumes a fixed 16-bit opcode with a 2-bit mode field at the bottom.
module tblwr_decode
    import tblwr_pkg::*;
#(
    parameter int IW = 16
) (
    input  logic [IW-1:0] word,
    output logic          is_tw,
    output tw_mode_e      mode
);
    localparam logic [IW-3:0] OPC_HI = (IW-2)'(3);

    // Match the fixed upper field and pass the mode bits through.
    always_comb begin
        is_tw = (word[IW-1:2] == OPC_HI);
        mode  = tw_mode_e'(word[1:0]);
    end
endmodule

// File: rtl/tblwr_ptr.sv
// Byte pointer register with load port and four-mode instruction update.
// Assumes update has priority over load; arithmetic wraps at 2^PTR_W.
// Also produces the holding-register index for the current write.
module tblwr_ptr
    import tblwr_pkg::*;
#(
    parameter int PTR_W = 21,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  tw_mode_e         mode,
    input  logic             ld,
    input  logic [PTR_W-1:0] ld_val,
    output logic [PTR_W-1:0] ptr_q,
    output logic [SEL_W-1:0] wr_sel
);
    logic [PTR_W-1:0] ptr_inc, ptr_dec, ptr_nxt;

    // Candidate next pointer for the current mode.
    always_comb begin
        ptr_inc = ptr_q + PTR_W'(1);
        ptr_dec = ptr_q - PTR_W'(1);
        unique case (mode)
            TW_KEEP:    ptr_nxt = ptr_q;
            TW_POSTDEC: ptr_nxt = ptr_dec;
            default:    ptr_nxt = ptr_inc;
        endcase
        wr_sel = (mode == TW_PREINC) ? ptr_inc[SEL_W-1:0] : ptr_q[SEL_W-1:0];
    end

    // Pointer register: reset, instruction update, then load.
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr_q <= '0;
        else if (upd) ptr_q <= ptr_nxt;
        else if (ld)  ptr_q <= ld_val;
    end

    p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && mode == TW_KEEP) |=> ptr_q == $past(ptr_q));
    p_postinc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && mode == TW_POSTINC) |=> ptr_q == $past(ptr_q) + PTR_W'(1));
    p_postdec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && mode == TW_POSTDEC) |=> ptr_q == $past(ptr_q) - PTR_W'(1));
    p_preinc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && mode == TW_PREINC) |=> ptr_q[SEL_W-1:0] == $past(wr_sel));
    p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !upd) |=> ptr_q == $past(ld_val));
    p_upd_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && upd && mode == TW_KEEP && ld_val != ptr_q) |=> ptr_q != $past(ld_val));
endmodule

// File: rtl/tblwr_hold.sv
// Bank of byte-wide holding registers with one write port and one
// combinational read port. Assumes NUM = 2**SEL_W entries.
module tblwr_hold #(
    parameter int DW    = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [DW-1:0]    wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [DW-1:0]    rd_data
);
    localparam int NUM = 1 << SEL_W;

    logic [DW-1:0] hold_q [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_entry
        // One holding register: cleared on reset, written when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                hold_q[g] <= '0;
            else if (wr && wr_sel == SEL_W'(g))
                hold_q[g] <= wr_data;
        end
    end

    // Combinational read mux.
    always_comb rd_data = hold_q[rd_sel];

    p_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> hold_q[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/tblwr_unit.sv
// Table-write unit top: accepts a table-write opcode, spends one busy
// cycle, then writes the latch into a holding register and updates the
// pointer on the same edge. Assumes a single outstanding instruction.
module tblwr_unit
    import tblwr_pkg::*;
#(
    parameter int PTR_W = 21,
    parameter int DW    = 8,
    parameter int SEL_W = 3,
    parameter int IW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [IW-1:0]    instr_word,
    input  logic             ptr_ld,
    input  logic [PTR_W-1:0] ptr_din,
    input  logic             lat_ld,
    input  logic [DW-1:0]    lat_din,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [DW-1:0]    rd_data,
    output logic [PTR_W-1:0] ptr_q,
    output logic [DW-1:0]    lat_q,
    output logic             busy,
    output logic             done
);
    logic             dec_is_tw;
    tw_mode_e         dec_mode;
    tw_mode_e         mode_q;
    logic             busy_q, done_q;
    logic             accept;
    logic [SEL_W-1:0] wr_sel;

    tblwr_decode #(.IW(IW)) u_dec (
        .word  (instr_word),
        .is_tw (dec_is_tw),
        .mode  (dec_mode)
    );

    // Acceptance only when idle and the word is a table write.
    always_comb accept = instr_valid && dec_is_tw && !busy_q;

    // Sequencer: accept -> busy cycle -> done cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            mode_q <= TW_KEEP;
        end else begin
            busy_q <= accept;
            done_q <= busy_q;
            if (accept) mode_q <= dec_mode;
        end
    end

    // Latch byte register.
    always_ff @(posedge clk) begin
        if (!rst_n)      lat_q <= '0;
        else if (lat_ld) lat_q <= lat_din;
    end

    tblwr_ptr #(.PTR_W(PTR_W), .SEL_W(SEL_W)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (busy_q),
        .mode   (mode_q),
        .ld     (ptr_ld),
        .ld_val (ptr_din),
        .ptr_q  (ptr_q),
        .wr_sel (wr_sel)
    );

    tblwr_hold #(.DW(DW), .SEL_W(SEL_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (busy_q),
        .wr_sel  (wr_sel),
        .wr_data (lat_q),
        .rd_sel  (rd_sel),
        .rd_data (rd_data)
    );

    always_comb begin
        busy = busy_q;
        done = done_q;
    end

    p_busy_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
    p_ignore_bad_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(instr_valid && instr_word[IW-1:2] == (IW-2)'(3))) |=> !busy);
endmodule

// File: tb/tblwr_unit_tb.sv
module tblwr_unit_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        instr_valid = 0;
    logic [15:0] instr_word = '0;
    logic        ptr_ld = 0;
    logic [20:0] ptr_din = '0;
    logic        lat_ld = 0;
    logic [7:0]  lat_din = '0;
    logic [2:0]  rd_sel = '0;
    logic [7:0]  rd_data;
    logic [20:0] ptr_q;
    logic [7:0]  lat_q;
    logic        busy, done;

    int n_run = 0, n_fail = 0;
    logic [20:0] m_ptr = '0;
    logic [7:0]  m_lat = '0;
    logic [7:0]  m_hold [8];

    always #5 clk = ~clk;

    tblwr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .ptr_ld(ptr_ld), .ptr_din(ptr_din), .lat_ld(lat_ld), .lat_din(lat_din),
        .rd_sel(rd_sel), .rd_data(rd_data), .ptr_q(ptr_q), .lat_q(lat_q),
        .busy(busy), .done(done)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_state(string tag);
        chk({tag, " ptr"}, 32'(ptr_q), 32'(m_ptr));
        for (int i = 0; i < 8; i++) begin
            rd_sel = 3'(i);
            #1;
            chk({tag, " hold"}, 32'(rd_data), 32'(m_hold[i]));
        end
    endtask

    task automatic set_ptr(logic [20:0] v);
        @(negedge clk); ptr_ld = 1; ptr_din = v;
        @(negedge clk); ptr_ld = 0;
        m_ptr = v;
    endtask

    task automatic set_lat(logic [7:0] v);
        @(negedge clk); lat_ld = 1; lat_din = v;
        @(negedge clk); lat_ld = 0;
        m_lat = v;
        chk("R10 latch load", 32'(lat_q), 32'(v));
    endtask

    task automatic model(logic [1:0] md);
        logic [20:0] inc = m_ptr + 21'd1;
        case (md)
            2'd0: m_hold[m_ptr[2:0]] = m_lat;
            2'd1: begin m_hold[m_ptr[2:0]] = m_lat; m_ptr = inc; end
            2'd2: begin m_hold[m_ptr[2:0]] = m_lat; m_ptr = m_ptr - 21'd1; end
            default: begin m_ptr = inc; m_hold[m_ptr[2:0]] = m_lat; end
        endcase
    endtask

    task automatic run_instr(logic [1:0] md, string tag);
        @(negedge clk); instr_valid = 1; instr_word = {14'h0003, md};
        @(negedge clk); instr_valid = 0;
        chk("R8 busy after accept", 32'(busy), 1);
        chk("R8 no done while busy", 32'(done), 0);
        @(negedge clk);
        chk("R8 busy drops", 32'(busy), 0);
        chk("R8 done pulse", 32'(done), 1);
        model(md);
        check_state(tag);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_hold[i] = '0;
        // Dirty the state before reset is observed.
        repeat (3) @(negedge clk);
        rst_n = 1;
        ptr_ld = 1; ptr_din = 21'h12345; lat_ld = 1; lat_din = 8'hAA;
        @(negedge clk);
        ptr_ld = 0; lat_ld = 0;
        instr_valid = 1; instr_word = 16'h000F;
        @(negedge clk); instr_valid = 0;
        rst_n = 0;
        repeat (2) @(negedge clk);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 latch", 32'(lat_q), 0);
        check_state("R1 reset");
        rst_n = 1;

        // Worked examples (R4, R6).
        set_ptr(21'h00A356); set_lat(8'h55);
        run_instr(2'd1, "R4 example");
        set_ptr(21'h01389A); set_lat(8'h34);
        run_instr(2'd3, "R6 example");

        // Sweep every mode over every low-pointer offset (R3..R6).
        for (int md = 0; md < 4; md++) begin
            for (int off = 0; off < 8; off++) begin
                set_ptr({18'(md * 4099 + off * 77), 3'(off)});
                set_lat(8'(md * 16 + off + 1));
                case (md)
                    0: run_instr(2'(md), "R3 keep");
                    1: run_instr(2'(md), "R4 postinc");
                    2: run_instr(2'(md), "R5 postdec");
                    default: run_instr(2'(md), "R6 preinc");
                endcase
            end
        end

        // Wrap at the pointer limits (R7).
        set_ptr(21'h1FFFFF); set_lat(8'hC1);
        run_instr(2'd1, "R7 inc wrap");
        set_ptr(21'h000000); set_lat(8'hC2);
        run_instr(2'd2, "R7 dec wrap");
        set_ptr(21'h1FFFFF); set_lat(8'hC3);
        run_instr(2'd3, "R7 preinc wrap");

        // Non-table-write words are ignored (R2).
        for (int k = 0; k < 16; k++) begin
            logic [15:0] w;
            w = (k < 12) ? 16'(k) : (k == 12 ? 16'h001C : (k == 13 ? 16'h100D : (k == 14 ? 16'h800E : 16'hFFFF)));
            @(negedge clk); instr_valid = 1; instr_word = w;
            @(negedge clk); instr_valid = 0;
            chk("R2 no busy", 32'(busy), 0);
            @(negedge clk);
            chk("R2 no done", 32'(done), 0);
        end
        check_state("R2 ignored");

        // Instruction while busy is dropped (R8).
        set_ptr(21'h000100); set_lat(8'h7E);
        @(negedge clk); instr_valid = 1; instr_word = 16'h000D;
        @(negedge clk); instr_word = 16'h000F;
        @(negedge clk); instr_valid = 0;
        chk("R8 second dropped busy", 32'(busy), 0);
        chk("R8 done", 32'(done), 1);
        model(2'd1);
        check_state("R8 busy ignore");

        // Load during update edge loses (R9).
        set_ptr(21'h000200); set_lat(8'h5A);
        @(negedge clk); instr_valid = 1; instr_word = 16'h000E;
        @(negedge clk); instr_valid = 0; ptr_ld = 1; ptr_din = 21'h0ABCDE;
        @(negedge clk); ptr_ld = 0;
        model(2'd2);
        check_state("R9 update wins");

        // Load in acceptance cycle applies first (R9).
        set_lat(8'hE7);
        @(negedge clk); instr_valid = 1; instr_word = 16'h000F; ptr_ld = 1; ptr_din = 21'h000305;
        @(negedge clk); instr_valid = 0; ptr_ld = 0;
        @(negedge clk);
        m_ptr = 21'h000305;
        model(2'd3);
        check_state("R9 load then instr");

        // Latch load during busy: write uses old latch (R10).
        set_ptr(21'h000010); set_lat(8'h11);
        @(negedge clk); instr_valid = 1; instr_word = 16'h000C;
        @(negedge clk); instr_valid = 0; lat_ld = 1; lat_din = 8'h99;
        @(negedge clk); lat_ld = 0;
        model(2'd0);
        m_lat = 8'h99;
        chk("R10 latch after", 32'(lat_q), 32'h99);
        check_state("R10 old latch written");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule